// File: doc/BRIEF.md
# Flash Read-Port Front End

This block is the read side of a parallel NOR flash model, clocked by a fast internal clock that samples the pins. It takes the chip-select, read-strobe and write-strobe pins (all active low), a word/byte width select, a word address and the 16-bit word that a memory-array stub returns for that address. It drives a data bus with one output enable per bit. The bus is driven only for a read cycle.

In byte width only the low lane is driven. The top data pin becomes an input that picks the low or high byte of the addressed word. A stability timer restarts on every address change, lane-pin change, width change or new read cycle. New data is latched onto the bus a fixed access time after that restart. If nothing changes for the access time plus a margin, the block reports a sleep state. In that state the latched data stays on the bus and no longer follows the array. The next address change wakes the block in the same cycle, and new data follows after the normal access time.

Top module: `flash_read_port`

## Requirements
- R1: In word width (`word_sel`=1) during a read, `dq_oe` is all ones and `dq_out` equals `arr_data` once the access time has passed.
- R2: In byte width (`word_sel`=0) during a read, `dq_oe` bits 7..0 are 1 and bits 15..8 are 0, so bit 15 is never driven and serves as an input.
- R3: In byte width, `dq15_in`=0 puts `arr_data[7:0]` on `dq_out[7:0]` and `dq15_in`=1 puts `arr_data[15:8]` there. `dq_out[15:8]` reads 0.
- R4: The bus is driven only while `ce_n`=0, `oe_n`=0 and `we_n`=1. In every other combination `dq_oe` is all zero.
- R5: `mode` reports 0 (standby) whenever `ce_n`=1, 1 (active) when selected and not asleep, and 2 (sleep).
- R6: A restart is the first clock edge that samples a changed address, lane pin or width, or the first edge of a read cycle. New data appears on `dq_out` after the T_ACC-th edge following the restart edge. Until then the previous data is held.
- R7: With a read held and inputs steady, `mode` becomes 2 after the (T_ACC+SLEEP_MARGIN)-th edge following the restart edge, and not before.
- R8: While asleep, `dq_out` and `dq_oe` hold their values even if `arr_data` changes.
- R9: An address change during sleep sets `mode` to 1 in the same cycle, before any clock edge. The new data then follows the timing of R6.
- R10: In word width, toggling `dq15_in` does not wake the block or change `dq_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low; high means standby |
| oe_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| word_sel | input | 1 | 1 = word width, 0 = byte width |
| addr | input | ADDR_W | Word address |
| dq15_in | input | 1 | Top data pin as input; byte-lane select in byte width |
| arr_data | input | DATA_W | Word returned by the array stub for `addr` |
| dq_out | output | DATA_W | Data bus output values |
| dq_oe | output | DATA_W | Per-bit output enables |
| mode | output | 2 | 0 standby, 1 active, 2 sleep |

## Verification
Two events can fall in the same cycle: entering or holding sleep, and an address change that must both wake the block and start a new access. The bench lets every swept address reach sleep. It then disturbs the array word and toggles the top pin in word width, and checks that the bus stays frozen. Next it changes the address half a clock before an edge and samples `mode` at once, expecting active. Finally it checks that the old data stays on the bus until exactly T_ACC edges later.

// File: rtl/fr_pkg.sv
package fr_pkg;
   typedef enum logic [1:0] {
      FR_STANDBY = 2'd0,
      FR_ACTIVE  = 2'd1,
      FR_SLEEP   = 2'd2
   } fr_mode_e;
endpackage

// File: rtl/fr_stable_timer.sv
module fr_stable_timer #(
   parameter int KEY_W     = 6,
   parameter int T_ACC     = 3,
   parameter int SLEEP_CYC = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd,
   input  logic [KEY_W-1:0] key,
   output logic             restart,
   output logic             load,
   output logic             asleep
);
   localparam int CNT_W = $clog2(SLEEP_CYC + 1);

   logic [KEY_W-1:0] key_q;
   logic             rd_q;
   logic [CNT_W-1:0] cnt;

   always_comb begin
      restart = rd & ((key != key_q) | ~rd_q);
      load    = rd & ~restart & (cnt == CNT_W'(T_ACC - 1));
      asleep  = rd & ~restart & (cnt == CNT_W'(SLEEP_CYC));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q <= '0;
         rd_q  <= 1'b0;
         cnt   <= '0;
      end else begin
         key_q <= key;
         rd_q  <= rd;
         if (!rd || restart)
            cnt <= '0;
         else if (cnt != CNT_W'(SLEEP_CYC))
            cnt <= cnt + 1'b1;
      end
   end

   AST_CNT_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(SLEEP_CYC)); // R7
   AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> !asleep && !load); // R4
endmodule

// File: rtl/fr_lane_sel.sv
module fr_lane_sel #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              word_sel,
   input  logic              lane_hi,
   input  logic [DATA_W-1:0] arr_data,
   output logic [DATA_W-1:0] data_q
);
   localparam int LANE_W = DATA_W / 2;

   logic [DATA_W-1:0] pick;

   always_comb begin
      if (word_sel)
         pick = arr_data;
      else if (lane_hi)
         pick = {{LANE_W{1'b0}}, arr_data[DATA_W-1:LANE_W]};
      else
         pick = {{LANE_W{1'b0}}, arr_data[LANE_W-1:0]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         data_q <= '0;
      else if (load)
         data_q <= pick;
   end

   AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      load && !word_sel |=> data_q[DATA_W-1:LANE_W] == '0); // R3
endmodule

// File: rtl/fr_bus_drv.sv
module fr_bus_drv #(
   parameter int DATA_W = 16
) (
   input  logic              rd,
   input  logic              word_sel,
   input  logic [DATA_W-1:0] data_q,
   output logic [DATA_W-1:0] dq_out,
   output logic [DATA_W-1:0] dq_oe
);
   localparam int LANE_W = DATA_W / 2;

   for (genvar g = 0; g < DATA_W; g++) begin : g_bit
      if (g < LANE_W) begin : g_low
         assign dq_oe[g] = rd;
      end else begin : g_high
         assign dq_oe[g] = rd & word_sel;
      end
   end

   assign dq_out = data_q;
endmodule

// File: rtl/flash_read_port.sv
module flash_read_port #(
   parameter int ADDR_W       = 4,
   parameter int DATA_W       = 16,
   parameter int T_ACC        = 3,
   parameter int SLEEP_MARGIN = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              word_sel,
   input  logic [ADDR_W-1:0] addr,
   input  logic              dq15_in,
   input  logic [DATA_W-1:0] arr_data,
   output logic [DATA_W-1:0] dq_out,
   output logic [DATA_W-1:0] dq_oe,
   output logic [1:0]        mode
);
   import fr_pkg::*;

   localparam int SLEEP_CYC = T_ACC + SLEEP_MARGIN;
   localparam int KEY_W     = ADDR_W + 2;

   if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
      $error("DATA_W must be even and at least 4");
   end
   if (T_ACC < 1) begin : g_bad_tacc
      $error("T_ACC must be at least 1");
   end
   if (SLEEP_MARGIN < 1) begin : g_bad_margin
      $error("SLEEP_MARGIN must be at least 1");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be at least 1");
   end

   logic              rd;
   logic [KEY_W-1:0]  key;
   logic              restart;
   logic              load;
   logic              asleep;
   logic [DATA_W-1:0] data_q;
   fr_mode_e          mode_e;

   assign rd  = ~ce_n & ~oe_n & we_n;
   assign key = {word_sel, addr, ~word_sel & dq15_in};

   fr_stable_timer #(
      .KEY_W     (KEY_W),
      .T_ACC     (T_ACC),
      .SLEEP_CYC (SLEEP_CYC)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd      (rd),
      .key     (key),
      .restart (restart),
      .load    (load),
      .asleep  (asleep)
   );

   fr_lane_sel #(.DATA_W(DATA_W)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .word_sel (word_sel),
      .lane_hi  (dq15_in),
      .arr_data (arr_data),
      .data_q   (data_q)
   );

   fr_bus_drv #(.DATA_W(DATA_W)) u_drv (
      .rd       (rd),
      .word_sel (word_sel),
      .data_q   (data_q),
      .dq_out   (dq_out),
      .dq_oe    (dq_oe)
   );

   always_comb begin
      if (ce_n)        mode_e = FR_STANDBY;
      else if (asleep) mode_e = FR_SLEEP;
      else             mode_e = FR_ACTIVE;
   end
   assign mode = mode_e;

   AST_SLEEP_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_e == FR_SLEEP) && $past(mode_e == FR_SLEEP) |-> $stable(dq_out)); // R8
   AST_SLEEP_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_e == FR_SLEEP) |-> dq_oe != '0); // R8
   AST_WAKE_NOW: assert property (@(posedge clk) disable iff (!rst_n)
      restart |-> mode_e != FR_SLEEP); // R9
   AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_e == FR_STANDBY) |-> dq_oe == '0); // R5
endmodule

// File: tb/flash_read_port_bench.sv
`timescale 1ns/1ps
module flash_read_port_bench;
   localparam int ADDR_W = 4;
   localparam int DATA_W = 16;
   localparam int T_ACC  = 3;
   localparam int MARGIN = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic              word_sel = 1'b1;
   logic [ADDR_W-1:0] addr = '0;
   logic              dq15_in = 1'b0;
   logic [DATA_W-1:0] scramble = '0;
   logic [DATA_W-1:0] arr_data;
   logic [DATA_W-1:0] dq_out, dq_oe;
   logic [1:0]        mode;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   always #10 clk = ~clk;

   function automatic logic [DATA_W-1:0] word_of(input logic [ADDR_W-1:0] a);
      return 16'((32'(a) * 32'd4957) ^ 32'hA5C3);
   endfunction

   assign arr_data = word_of(addr) ^ scramble;

   flash_read_port #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .T_ACC(T_ACC), .SLEEP_MARGIN(MARGIN)
   ) u_flash_read_port (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .word_sel(word_sel), .addr(addr), .dq15_in(dq15_in), .arr_data(arr_data),
      .dq_out(dq_out), .dq_oe(dq_oe), .mode(mode)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic negs(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(20.0 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [DATA_W-1:0] prev, exp_w;
      negs(3);
      chk("R5 reset mode", 32'(mode), 32'd0);
      chk("R4 reset oe", 32'(dq_oe), 32'd0);
      chk("R6 reset data", 32'(dq_out), 32'd0);
      rst_n = 1'b1;
      negs(2);
      ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; word_sel = 1'b1; addr = '0;
      #2;
      chk("R5 selected mode", 32'(mode), 32'd1);
      chk("R1 word oe", 32'(dq_oe), 32'hFFFF);
      @(negedge clk);
      prev = '0;
      // word-width sweep
      for (int a = 0; a < (1 << ADDR_W); a++) begin
         if (a != 0) begin
            addr = ADDR_W'(a);
            #2;
            chk("R9 wake same cycle", 32'(mode), 32'd1);
            negs(1);
         end
         exp_w = word_of(ADDR_W'(a));
         negs(T_ACC - 1);
         if (a != 0) chk("R6 old data held", 32'(dq_out), 32'(prev));
         negs(1);
         chk("R1 word data", 32'(dq_out), 32'(exp_w));
         chk("R1 word oe", 32'(dq_oe), 32'hFFFF);
         chk("R5 active", 32'(mode), 32'd1);
         negs(MARGIN - 1);
         chk("R7 not yet asleep", 32'(mode), 32'd1);
         negs(1);
         chk("R7 asleep", 32'(mode), 32'd2);
         scramble = 16'h5A5A;
         negs(2);
         chk("R8 data frozen", 32'(dq_out), 32'(exp_w));
         chk("R8 oe kept", 32'(dq_oe), 32'hFFFF);
         chk("R8 still asleep", 32'(mode), 32'd2);
         dq15_in = ~dq15_in;
         #2;
         chk("R10 top pin ignored mode", 32'(mode), 32'd2);
         negs(2);
         chk("R10 top pin ignored data", 32'(dq_out), 32'(exp_w));
         chk("R10 still asleep", 32'(mode), 32'd2);
         scramble = '0;
         prev = exp_w;
         negs(1);
      end
      // byte-width sweep
      word_sel = 1'b0;
      for (int a = 0; a < (1 << ADDR_W); a++) begin
         for (int h = 0; h < 2; h++) begin
            addr = ADDR_W'(a);
            dq15_in = h[0];
            exp_w = word_of(ADDR_W'(a));
            exp_w = h[0] ? {8'h00, exp_w[15:8]} : {8'h00, exp_w[7:0]};
            #2;
            chk("R2 byte oe", 32'(dq_oe), 32'h00FF);
            chk("R9 byte wake", 32'(mode), 32'd1);
            negs(1 + T_ACC);
            chk("R3 byte lane data", 32'(dq_out), 32'(exp_w));
            negs(MARGIN);
            chk("R7 byte asleep", 32'(mode), 32'd2);
            negs(1);
         end
      end
      // enable combinations
      word_sel = 1'b1; addr = 4'd5; dq15_in = 1'b0;
      negs(T_ACC + 2);
      chk("R1 word after byte", 32'(dq_out), 32'(word_of(4'd5)));
      oe_n = 1'b1; #2;
      chk("R4 oe_n high", 32'(dq_oe), 32'd0);
      chk("R5 oe_n high mode", 32'(mode), 32'd1);
      @(negedge clk);
      oe_n = 1'b0; we_n = 1'b0; #2;
      chk("R4 we_n low", 32'(dq_oe), 32'd0);
      @(negedge clk);
      we_n = 1'b1; ce_n = 1'b1; #2;
      chk("R4 ce_n high", 32'(dq_oe), 32'd0);
      chk("R5 standby", 32'(mode), 32'd0);
      negs(2);
      ce_n = 1'b0; addr = 4'd9;
      negs(T_ACC);
      chk("R6 new read old data", 32'(dq_out), 32'(word_of(4'd5)));
      negs(1);
      chk("R6 new read data", 32'(dq_out), 32'(word_of(4'd9)));
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule